// File: doc/BRIEF.md
# Peripheral Control Register with Boot Lock

This block holds the static configuration of a serial packet interface. It has one 32-bit control word and a bank of four configuration words. Each of the four words is read-only in normal use, and its reset value is set by a parameter. Software reaches all five words through a single-cycle port. A cycle with `req` high is one access. `we` selects a write, which always replaces the full word. Read data depends only on `addr` and is valid in the same cycle.

The control word drives these outputs: the memory sleep override, loopback, a boot-done flag, three 3-bit transmit watermarks, a bus transaction priority, a single-lane flag, a prescaler select and four PLL enables. Boot-done works as a one-shot lock. Software sets it with an ordinary write, and only reset clears it. While boot-done is clear, software may overwrite the configuration bank. Once it is set, writes to the bank are refused, and the refused write and any access to an unmapped address produce a one-cycle `err` pulse.

Word address map: 0 is the control word, 1 to 4 are configuration words 0 to 3, and all other addresses are unmapped.

Top module: `perctl_reg`

## Requirements
- R1: After reset the control word reads 0x0005_3000. In that value the priority-2 watermark is 1, the priority-1 watermark is 2, the priority-0 watermark is 3, and every other field is 0. Configuration word i reads its parameter value `CFG_RSTi`.
- R2: Control bits 31..27 and 23..21 always read 0, whatever was written to them.
- R3: The control word fields drive the outputs as follows:
  - bit 26 → `mem_awake`
  - bit 25 → `loop_en`
  - bit 24 → `boot_done`
  - bits 20..18 → `txwm_p2`
  - bits 17..15 → `txwm_p1`
  - bits 14..12 → `txwm_p0`
  - bits 11..9 → `bus_pri`
  - bit 8 → `lane1_mode`
  - bits 7..4 → `presc_sel`
  - bits 3..0 → `pll_en`

  A write to address 0 updates these outputs on the next clock edge.
- R4: Writing 1 to bit 24 sets `boot_done`. A later write of 0 to that bit does not clear it. Only reset clears it.
- R5: While `boot_done` is 0, a write to addresses 1..4 replaces that configuration word. The new value appears on `rdata` and on `cfg_out[32*i +: 32]`, and `err` stays low.
- R6: While `boot_done` is 1, a write to addresses 1..4 leaves every configuration word unchanged. `err` is high for exactly the one cycle after that access.
- R7: A read of addresses 0..4 returns the stored word and never raises `err`, whatever the state of `boot_done`.
- R8: An access to addresses 5..15 reads as 0 and raises `err` for the one cycle after it. A write there changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| err | output | 1 | One-cycle pulse after a refused or unmapped access |
| mem_awake | output | 1 | Memories kept awake during shutdown |
| loop_en | output | 1 | Digital loopback of transmit onto receive |
| boot_done | output | 1 | Configuration bank locked |
| txwm_p2 | output | 3 | Transmit watermark, priority 2 |
| txwm_p1 | output | 3 | Transmit watermark, priority 1 |
| txwm_p0 | output | 3 | Transmit watermark, priority 0 |
| bus_pri | output | 3 | Bus transaction priority |
| lane1_mode | output | 1 | Single-lane mode |
| presc_sel | output | 4 | Prescaler select |
| pll_en | output | 4 | PLL enables |
| cfg_out | output | 128 | Configuration bank, word i at bits 32*i+31..32*i |

## Verification
The hardest state to reach is the locked state, because boot-done can only be set and never cleared. The stimulus therefore keeps bit 24 at 0 through all the walking-bit writes to the control word. Still unlocked, it fills the bank with new values. Only after that does it set the lock, and it then replays writes to every bank address and a write that tries to clear the lock. This reaches both sides of the lock within a single reset.

// File: rtl/perctl_reg.sv
module perctl_reg #(
  parameter int          AW       = 4,
  parameter logic [31:0] CFG_RST0 = 32'h0000_0000,
  parameter logic [31:0] CFG_RST1 = 32'h0000_0000,
  parameter logic [31:0] CFG_RST2 = 32'h0000_0000,
  parameter logic [31:0] CFG_RST3 = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          err,
  output logic          mem_awake,
  output logic          loop_en,
  output logic          boot_done,
  output logic [2:0]    txwm_p2,
  output logic [2:0]    txwm_p1,
  output logic [2:0]    txwm_p0,
  output logic [2:0]    bus_pri,
  output logic          lane1_mode,
  output logic [3:0]    presc_sel,
  output logic [3:0]    pll_en,
  output logic [127:0]  cfg_out
);
  localparam int NCFG = 4;
  localparam logic [NCFG-1:0][31:0] CFG_RST = {CFG_RST3, CFG_RST2, CFG_RST1, CFG_RST0};

  logic [31:0] cfg [NCFG];
  logic [31:0] ctrl_rd;
  logic        hit_ctrl, hit_cfg;
  logic [1:0]  idx;
  logic [AW-1:0] addr_m1;

  assign hit_ctrl = (addr == '0);
  assign hit_cfg  = (addr >= AW'(1)) && (addr <= AW'(NCFG));
  assign addr_m1  = addr - AW'(1);
  assign idx      = addr_m1[1:0];

  assign ctrl_rd = {5'b0, mem_awake, loop_en, boot_done, 3'b0,
                    txwm_p2, txwm_p1, txwm_p0, bus_pri, lane1_mode, presc_sel, pll_en};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_awake  <= 1'b0;
      loop_en    <= 1'b0;
      boot_done  <= 1'b0;
      txwm_p2    <= 3'd1;
      txwm_p1    <= 3'd2;
      txwm_p0    <= 3'd3;
      bus_pri    <= 3'd0;
      lane1_mode <= 1'b0;
      presc_sel  <= 4'd0;
      pll_en     <= 4'd0;
    end else if (req && we && hit_ctrl) begin
      mem_awake  <= wdata[26];
      loop_en    <= wdata[25];
      boot_done  <= boot_done | wdata[24];
      txwm_p2    <= wdata[20:18];
      txwm_p1    <= wdata[17:15];
      txwm_p0    <= wdata[14:12];
      bus_pri    <= wdata[11:9];
      lane1_mode <= wdata[8];
      presc_sel  <= wdata[7:4];
      pll_en     <= wdata[3:0];
    end
  end

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg[i] <= CFG_RST[i];
      else if (req && we && hit_cfg && !boot_done && idx == 2'(i))
        cfg[i] <= wdata;
    end
    assign cfg_out[32*i +: 32] = cfg[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err <= 1'b0;
    else        err <= req && ((!hit_ctrl && !hit_cfg) || (we && hit_cfg && boot_done));
  end

  assign rdata = hit_ctrl ? ctrl_rd : hit_cfg ? cfg[idx] : 32'h0;
endmodule

// File: rtl/perctl_reg_chk.sv
module perctl_reg_chk #(parameter int AW = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          req,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [31:0]   rdata,
  input logic          err,
  input logic          boot_done,
  input logic [127:0]  cfg_out
);
  logic unmapped;
  assign unmapped = addr > AW'(4);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == '0) |-> (rdata[31:27] == 5'b0 && rdata[23:21] == 3'b0));

  p_boot_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> boot_done);

  p_locked_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && boot_done && !unmapped && addr != '0) |=> ($stable(cfg_out) && err));

  p_read_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !we && !unmapped) |=> !err);

  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (rdata == 32'h0));

  p_unmapped_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && unmapped) |=> (err && $stable(cfg_out)));

  p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!req) |=> !err);
endmodule

bind perctl_reg perctl_reg_chk #(.AW(AW)) u_chk (.*);

// File: tb/perctl_reg_bench.sv
module perctl_reg_bench;
  localparam logic [31:0] C0 = 32'hA5A5_0001, C1 = 32'h5A5A_0002,
                          C2 = 32'hDEAD_0003, C3 = 32'hBEEF_0004;
  localparam logic [31:0] MASK = 32'h071F_FFFF;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic err, mem_awake, loop_en, boot_done, lane1_mode;
  logic [2:0] txwm_p2, txwm_p1, txwm_p0, bus_pri;
  logic [3:0] presc_sel, pll_en;
  logic [127:0] cfg_out;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  perctl_reg #(.AW(4), .CFG_RST0(C0), .CFG_RST1(C1), .CFG_RST2(C2), .CFG_RST3(C3)) u_perctl_reg (.*);

  task automatic cmp(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic e);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    #1 rd = rdata;
    @(negedge clk);
    req = 0; we = 0;
    e = err;
  endtask

  function automatic logic [31:0] outs();
    return {5'b0, mem_awake, loop_en, boot_done, 3'b0, txwm_p2, txwm_p1, txwm_p0,
            bus_pri, lane1_mode, presc_sel, pll_en};
  endfunction

  initial begin
    logic [31:0] rd, bank [4];
    logic e;
    bank[0] = C0; bank[1] = C1; bank[2] = C2; bank[3] = C3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    acc(0, 0, 0, rd, e);
    cmp("R1 ctrl reset", rd, 32'h0005_3000);
    cmp("R1 outputs reset", outs(), 32'h0005_3000);
    for (int i = 0; i < 4; i++) begin
      acc(0, 4'(i + 1), 0, rd, e);
      cmp("R1 cfg reset", rd, bank[i]);
      cmp("R7 read no err", e, 0);
    end
    for (int b = 0; b < 32; b++) begin
      if (b == 24) continue;
      acc(1, 0, 32'h1 << b, rd, e);
      cmp("R3 outputs after write", outs(), (32'h1 << b) & MASK);
      acc(0, 0, 0, rd, e);
      cmp("R2 readback masked", rd, (32'h1 << b) & MASK);
      cmp("R7 ctrl read no err", e, 0);
    end
    for (int i = 0; i < 4; i++) begin
      bank[i] = 32'h1357_9BDF ^ (32'h0101_0101 * (i + 3));
      acc(1, 4'(i + 1), bank[i], rd, e);
      cmp("R5 write no err", e, 0);
    end
    for (int i = 0; i < 4; i++) begin
      acc(0, 4'(i + 1), 0, rd, e);
      cmp("R5 cfg readback", rd, bank[i]);
      cmp("R5 cfg_out", cfg_out[32*i +: 32], bank[i]);
    end
    acc(1, 0, 32'hFFFF_FFFF, rd, e);
    acc(0, 0, 0, rd, e);
    cmp("R2 all-ones readback", rd, MASK);
    cmp("R4 boot set", boot_done, 1);
    acc(1, 0, 32'h0000_0ABC, rd, e);
    cmp("R4 boot sticky", boot_done, 1);
    cmp("R3 fields after lock", outs(), 32'h0100_0ABC);
    for (int i = 0; i < 4; i++) begin
      acc(1, 4'(i + 1), ~bank[i], rd, e);
      cmp("R6 locked write err", e, 1);
      @(negedge clk);
      cmp("R6 err one cycle", err, 0);
      acc(0, 4'(i + 1), 0, rd, e);
      cmp("R6 cfg unchanged", rd, bank[i]);
      cmp("R7 locked read no err", e, 0);
    end
    for (int a = 5; a < 16; a++) begin
      acc(0, 4'(a), 0, rd, e);
      cmp("R8 unmapped read zero", rd, 0);
      cmp("R8 unmapped read err", e, 1);
      acc(1, 4'(a), 32'hFFFF_FFFF, rd, e);
      cmp("R8 unmapped write err", e, 1);
      cmp("R8 ctrl untouched", outs(), 32'h0100_0ABC);
      cmp("R8 bank untouched", cfg_out, {bank[3], bank[2], bank[1], bank[0]});
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule